// File: doc/BRIEF.md
# Dual DMA Controller Port Decoder with Page Registers

This block sits between an 8-bit I/O bus and two DMA controllers. On every access it works out which device owns the port. It then forwards the strobe and a register index to the primary or secondary controller's register bus, or it serves the access from its own bank of six 8-bit page registers. The page registers supply the upper address bits of channels 1, 2, 3, 5, 6 and 7. Each value is also brought out on its own output so that a transfer engine can extend its addresses.

A static enable input includes or removes the secondary controller. When the secondary controller is removed, its port window and its three page ports are no longer claimed. Another device on the bus can then answer those ports. Decoding and read data are combinational within the access cycle. Page writes take effect at the rising clock edge on which the write strobe is high.

Top module: `dma_port_decode`

## Requirements
- R1: Ports 0x00 to 0x0F are claimed and forwarded to the primary controller. The register index is the low four bits of the port. The primary read or write strobe follows the bus strobe.
- R2: With the secondary controller enabled, ports 0xC0 to 0xDF are claimed and forwarded to the secondary controller. The register index is bits 4 to 1 of the port, which equals (port - 0xC0) / 2.
- R3: A write to port 0x81 sets the page of channel 2, a write to 0x82 sets channel 3, and a write to 0x83 sets channel 1.
- R4: With the secondary controller enabled, a write to port 0x89 sets the page of channel 6, a write to 0x8A sets channel 7, and a write to 0x8B sets channel 5.
- R5: A read of a page port returns the last value written to it. A page register changes only on a write to its own port.
- R6: A read of any port the block does not decode returns 0x00. Such a port leaves the claim output low and raises no controller strobe.
- R7: With the secondary controller disabled, ports 0xC0 to 0xDF and 0x89 to 0x8B are not claimed and raise no secondary strobe. Reads of them return 0x00, and writes to them leave pages 5, 6 and 7 unchanged. The primary controller ports and the primary page ports keep working.
- R8: Reset clears all six page registers to 0x00.
- R9: The claim output and the read data are active only while a read or write strobe is high. With no read strobe the read data is 0x00.
- R10: A read of a controller port returns, in the same cycle, the read data of the controller that owns the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_enable | input | 1 | Static: 1 includes the secondary controller |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 8 | I/O read data |
| io_claim | output | 1 | The block owns the current access |
| pri_rd | output | 1 | Primary controller read strobe |
| pri_wr | output | 1 | Primary controller write strobe |
| pri_idx | output | 4 | Primary controller register index |
| pri_wdata | output | 8 | Primary controller write data |
| pri_rdata | input | 8 | Primary controller read data |
| sec_rd | output | 1 | Secondary controller read strobe |
| sec_wr | output | 1 | Secondary controller write strobe |
| sec_idx | output | 4 | Secondary controller register index |
| sec_wdata | output | 8 | Secondary controller write data |
| sec_rdata | input | 8 | Secondary controller read data |
| page_c1 | output | 8 | Page of channel 1 |
| page_c2 | output | 8 | Page of channel 2 |
| page_c3 | output | 8 | Page of channel 3 |
| page_c5 | output | 8 | Page of channel 5 |
| page_c6 | output | 8 | Page of channel 6 |
| page_c7 | output | 8 | Page of channel 7 |

## Verification
Some properties are checked by assertions on every cycle:
- a controller strobe appears only with a matching bus strobe and a port in that controller's window;
- the two controllers are never strobed together;
- page registers hold while there is no write;
- a disabled secondary controller neither sees strobes nor lets its pages change;
- unclaimed reads return zero.

Other behaviour can only be shown by the bench's scenarios. This covers the mapping of each page port to its channel in its out-of-sequence order, the halved index on the secondary window, the read-back of written pages and the pass-through of controller read data.

// File: rtl/dma_dec_pkg.sv
package dma_dec_pkg;
    localparam int PORT_W = 8;
    localparam int IDX_W  = 4;
    localparam int CHAN_W = 3;
    localparam int NCHAN  = 1 << CHAN_W;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PRI  = 2'd1,
        TGT_SEC  = 2'd2,
        TGT_PAGE = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [IDX_W-1:0]  idx;
        logic [CHAN_W-1:0] chan;
    } dec_s;
endpackage

// File: rtl/dma_port_classify.sv
module dma_port_classify
    import dma_dec_pkg::*;
(
    input  logic [PORT_W-1:0] port,
    input  logic              sec_en,
    output dec_s              dec
);
    logic is_pri, is_sec, is_page_lo, is_page_hi;
    logic [CHAN_W-2:0] low_chan;

    always_comb begin
        is_pri     = (port[7:4] == 4'h0);
        is_sec     = sec_en && (port[7:5] == 3'b110);
        is_page_lo = (port[7:2] == 6'b100000) && (port[1:0] != 2'b00);
        is_page_hi = sec_en && (port[7:2] == 6'b100010) && (port[1:0] != 2'b00);

        // port low bits 1,2,3 select channel 2,3,1 of each group
        case (port[1:0])
            2'd1:    low_chan = 2'd2;
            2'd2:    low_chan = 2'd3;
            default: low_chan = 2'd1;
        endcase

        dec = '0;
        if (is_pri) begin
            dec.tgt = TGT_PRI;
            dec.idx = port[IDX_W-1:0];
        end else if (is_sec) begin
            dec.tgt = TGT_SEC;
            dec.idx = port[IDX_W:1];
        end else if (is_page_lo || is_page_hi) begin
            dec.tgt  = TGT_PAGE;
            dec.chan = {port[3], low_chan};
        end
    end
endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CHAN_W-1:0]       chan,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [NCHAN*DATA_W-1:0] pages_flat
);
    localparam int GROUP = NCHAN / 2;

    typedef struct packed {
        logic [NCHAN-1:0][DATA_W-1:0] pg;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NCHAN; i++) begin
            // the first channel of each controller has no page register
            if (wr_en && (chan == CHAN_W'(i)) && ((i % GROUP) != 0))
                bank_d.pg[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rdata = bank_q.pg[chan];

    for (genvar g = 0; g < NCHAN; g++) begin : g_out
        assign pages_flat[g*DATA_W +: DATA_W] = bank_q.pg[g];
    end
endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
    import dma_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  tgt_e              tgt,
    input  logic              rd,
    input  logic [DATA_W-1:0] pri_rdata,
    input  logic [DATA_W-1:0] sec_rdata,
    input  logic [DATA_W-1:0] page_rdata,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (tgt)
                TGT_PRI:  rdata = pri_rdata;
                TGT_SEC:  rdata = sec_rdata;
                TGT_PAGE: rdata = page_rdata;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_enable,
    input  logic [7:0]        io_port,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_claim,
    output logic              pri_rd,
    output logic              pri_wr,
    output logic [3:0]        pri_idx,
    output logic [DATA_W-1:0] pri_wdata,
    input  logic [DATA_W-1:0] pri_rdata,
    output logic              sec_rd,
    output logic              sec_wr,
    output logic [3:0]        sec_idx,
    output logic [DATA_W-1:0] sec_wdata,
    input  logic [DATA_W-1:0] sec_rdata,
    output logic [DATA_W-1:0] page_c1,
    output logic [DATA_W-1:0] page_c2,
    output logic [DATA_W-1:0] page_c3,
    output logic [DATA_W-1:0] page_c5,
    output logic [DATA_W-1:0] page_c6,
    output logic [DATA_W-1:0] page_c7
);
    dec_s                    dec;
    logic [DATA_W-1:0]       page_rdata;
    logic [NCHAN*DATA_W-1:0] pages_flat;
    logic                    access;

    dma_port_classify u_cls (
        .port   (io_port),
        .sec_en (sec_enable),
        .dec    (dec)
    );

    assign access    = io_rd | io_wr;
    assign io_claim  = access && (dec.tgt != TGT_NONE);
    assign pri_rd    = io_rd && (dec.tgt == TGT_PRI);
    assign pri_wr    = io_wr && (dec.tgt == TGT_PRI);
    assign sec_rd    = io_rd && (dec.tgt == TGT_SEC);
    assign sec_wr    = io_wr && (dec.tgt == TGT_SEC);
    assign pri_idx   = dec.idx;
    assign sec_idx   = dec.idx;
    assign pri_wdata = io_wdata;
    assign sec_wdata = io_wdata;

    dma_page_bank #(.DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (io_wr && (dec.tgt == TGT_PAGE)),
        .chan       (dec.chan),
        .wdata      (io_wdata),
        .rdata      (page_rdata),
        .pages_flat (pages_flat)
    );

    dma_read_mux #(.DATA_W(DATA_W)) u_mux (
        .tgt        (dec.tgt),
        .rd         (io_rd),
        .pri_rdata  (pri_rdata),
        .sec_rdata  (sec_rdata),
        .page_rdata (page_rdata),
        .rdata      (io_rdata)
    );

    assign page_c1 = pages_flat[1*DATA_W +: DATA_W];
    assign page_c2 = pages_flat[2*DATA_W +: DATA_W];
    assign page_c3 = pages_flat[3*DATA_W +: DATA_W];
    assign page_c5 = pages_flat[5*DATA_W +: DATA_W];
    assign page_c6 = pages_flat[6*DATA_W +: DATA_W];
    assign page_c7 = pages_flat[7*DATA_W +: DATA_W];
endmodule

// File: rtl/dma_port_decode_chk.sv
module dma_port_decode_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_enable,
    input logic [7:0]        io_port,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_rdata,
    input logic              io_claim,
    input logic              pri_rd,
    input logic              pri_wr,
    input logic              sec_rd,
    input logic              sec_wr,
    input logic [DATA_W-1:0] page_c1,
    input logic [DATA_W-1:0] page_c2,
    input logic [DATA_W-1:0] page_c3,
    input logic [DATA_W-1:0] page_c5,
    input logic [DATA_W-1:0] page_c6,
    input logic [DATA_W-1:0] page_c7
);
    p_pri_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_rd || pri_wr) |-> ((io_rd || io_wr) && io_port < 8'h10));

    p_sec_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_rd || sec_wr) |-> (sec_enable && io_port >= 8'hC0 && io_port <= 8'hDF));

    p_one_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pri_rd | pri_wr, sec_rd | sec_wr}));

    p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable({page_c1, page_c2, page_c3, page_c5, page_c6, page_c7}));

    p_sec_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_enable |-> (!sec_rd && !sec_wr));

    p_sec_pages_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_enable |=> $stable({page_c5, page_c6, page_c7}));

    p_unclaimed_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_claim) |-> (io_rdata == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd && !io_wr) |-> (!io_claim && io_rdata == '0));
endmodule

bind dma_port_decode dma_port_decode_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dma_port_decode_test.sv
module dma_port_decode_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_enable = 1'b1;
    logic [7:0] io_port = '0;
    logic [7:0] io_wdata = '0;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_rdata;
    logic       io_claim;
    logic       pri_rd, pri_wr, sec_rd, sec_wr;
    logic [3:0] pri_idx, sec_idx;
    logic [7:0] pri_wdata, sec_wdata;
    logic [7:0] pri_rdata = 8'h5A;
    logic [7:0] sec_rdata = 8'hC3;
    logic [7:0] page_c1, page_c2, page_c3, page_c5, page_c6, page_c7;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dma_port_decode uut (.*);

    // vector: port[13:6], target[5:4] (0 none,1 pri,2 sec,3 page), index[3:0]
    localparam int NV = 15;
    localparam logic [13:0] VEC [NV] = '{
        {8'h00, 2'd1, 4'h0}, {8'h0A, 2'd1, 4'hA}, {8'h0F, 2'd1, 4'hF},
        {8'hC0, 2'd2, 4'h0}, {8'hC2, 2'd2, 4'h1}, {8'hC5, 2'd2, 4'h2},
        {8'hDE, 2'd2, 4'hF}, {8'h81, 2'd3, 4'h0}, {8'h8B, 2'd3, 4'h0},
        {8'h10, 2'd0, 4'h0}, {8'h80, 2'd0, 4'h0}, {8'h84, 2'd0, 4'h0},
        {8'h8C, 2'd0, 4'h0}, {8'hBF, 2'd0, 4'h0}, {8'hE0, 2'd0, 4'h0}
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        io_port = p; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] p, output logic [7:0] d, output logic c);
        @(negedge clk);
        io_port = p; io_rd = 1'b1;
        #2;
        d = io_rdata; c = io_claim;
        io_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       c;
        repeat (3) @(negedge clk);
        // R8: reset state
        check8("R8 c1", page_c1, 8'h00); check8("R8 c2", page_c2, 8'h00);
        check8("R8 c3", page_c3, 8'h00); check8("R8 c5", page_c5, 8'h00);
        check8("R8 c6", page_c6, 8'h00); check8("R8 c7", page_c7, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle bus
        check8("R9 idle claim", {7'd0, io_claim}, 8'h00);
        check8("R9 idle rdata", io_rdata, 8'h00);

        // R1 R2 R6: decode table
        for (int i = 0; i < NV; i++) begin
            logic [7:0] p;
            logic [1:0] t;
            logic [3:0] x;
            {p, t, x} = VEC[i];
            @(negedge clk);
            io_port = p; io_rd = 1'b1;
            #2;
            check8($sformatf("R1/R2/R6 claim port %02h", p), {7'd0, io_claim}, {7'd0, t != 2'd0});
            check8($sformatf("R1 pri_rd port %02h", p), {7'd0, pri_rd}, {7'd0, t == 2'd1});
            check8($sformatf("R2 sec_rd port %02h", p), {7'd0, sec_rd}, {7'd0, t == 2'd2});
            if (t == 2'd1) begin
                check8("R1 index", {4'd0, pri_idx}, {4'd0, x});
                check8("R10 pri data", io_rdata, 8'h5A);
            end
            if (t == 2'd2) begin
                check8("R2 index", {4'd0, sec_idx}, {4'd0, x});
                check8("R10 sec data", io_rdata, 8'hC3);
            end
            if (t == 2'd0) check8("R6 unmapped data", io_rdata, 8'h00);
            io_rd = 1'b0;
        end

        // R1: write strobe forwarding
        @(negedge clk);
        io_port = 8'h0B; io_wdata = 8'h96; io_wr = 1'b1;
        #2;
        check8("R1 pri_wr", {7'd0, pri_wr}, 8'h01);
        check8("R1 pri_wdata", pri_wdata, 8'h96);
        io_wr = 1'b0;

        // R3 R4: page mapping
        io_write(8'h81, 8'h12); io_write(8'h82, 8'h23); io_write(8'h83, 8'h31);
        io_write(8'h89, 8'h66); io_write(8'h8A, 8'h77); io_write(8'h8B, 8'h55);
        check8("R3 c2", page_c2, 8'h12); check8("R3 c3", page_c3, 8'h23);
        check8("R3 c1", page_c1, 8'h31); check8("R4 c6", page_c6, 8'h66);
        check8("R4 c7", page_c7, 8'h77); check8("R4 c5", page_c5, 8'h55);

        // R5: read back
        io_read(8'h83, d, c); check8("R5 rd 83", d, 8'h31);
        io_read(8'h8B, d, c); check8("R5 rd 8B", d, 8'h55);
        io_read(8'h82, d, c); check8("R5 rd 82", d, 8'h23);
        io_write(8'h80, 8'hEE);
        io_write(8'h84, 8'hEE);
        check8("R5 untouched c1", page_c1, 8'h31);
        check8("R5 untouched c2", page_c2, 8'h12);

        // R7: secondary disabled
        sec_enable = 1'b0;
        @(negedge clk);
        io_write(8'h8B, 8'hAB);
        io_write(8'h89, 8'hAB);
        check8("R7 c5 kept", page_c5, 8'h55);
        check8("R7 c6 kept", page_c6, 8'h66);
        io_read(8'h8A, d, c);
        check8("R7 page read", d, 8'h00);
        check8("R7 page claim", {7'd0, c}, 8'h00);
        @(negedge clk);
        io_port = 8'hC4; io_rd = 1'b1;
        #2;
        check8("R7 sec claim", {7'd0, io_claim}, 8'h00);
        check8("R7 sec_rd", {7'd0, sec_rd}, 8'h00);
        check8("R7 sec data", io_rdata, 8'h00);
        io_rd = 1'b0;
        io_write(8'h81, 8'h9C);
        check8("R7 primary page works", page_c2, 8'h9C);
        io_read(8'h03, d, c);
        check8("R7 primary ctrl works", d, 8'h5A);

        // R8: reset again clears pages
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check8("R8 c2 after reset", page_c2, 8'h00);
        check8("R8 c7 after reset", page_c7, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule